// File: doc/BRIEF.md
# SPI Flash User-Command Transfer Engine

This block is a register-controlled SPI master that runs one transfer at a time, started by software. The transfer length is set in bits and can be anything up to the size of an internal 64-byte data buffer. Software loads the bytes to send into the buffer, sets the bit count, the clock and chip-select polarity and whether chip select stays asserted afterwards, then writes the start bit. The engine shifts the buffer out on MOSI. When capture is enabled, it samples MISO on every bit and writes each received bit back into the buffer position whose bit was just sent. When the last bit has been shifted, a done flag in the status register is set.

The serial clock rate is set outside the block: a separate divider supplies a one-cycle bit-tick enable. Each tick advances the serial clock by one edge, so one bit takes two ticks. Chip select can be kept asserted across chained transfers, so a command, an address and a data phase can form one bus transaction with no gap between them. A self-clearing soft reset aborts any transfer and returns the configuration to its reset state. A slave-mode bit blocks transfers from starting.

Top module: `spi_user_xfer`

## Requirements
- R1: After reset every control register reads 0, chip select is deasserted (spi_cs_o high), spi_sck_o is low and spi_mosi_o is low.
- R2: Writing 1 to bit 18 of the command register (0x00) starts a transfer, and that bit reads 1 while the transfer is in progress. Bit n of the transfer comes from buffer byte n/8, most significant bit first. Buffer byte k sits in bits 8*(k%4)+7 : 8*(k%4) of the word at 0x40+4*(k/4).
- R3: The bit-count register (0x20) holds the number of bits minus one in bits 25:17. The transfer shifts exactly that many bits plus one, so a value of 7 shifts one byte.
- R4: Status bit 4 (register 0x30) is set when the last bit completes. A status write with bit 4 at 0 clears it.
- R5: When user-register (0x1C) bit 0 is set, the MISO bit sampled for transfer bit n replaces the buffer bit that was sent as bit n. When bit 0 is clear, the buffer is left unchanged.
- R6: When chip-select register (0x2C) bit 30 is set, chip select stays asserted after the last bit, and a following start reuses it with no deassertion in between. When bit 30 is clear, chip select is released once the last bit completes.
- R7: Chip-select register bit 23 makes chip select active-high. User-register bit 7 makes the serial clock idle high.
- R8: MOSI changes only on the leading serial-clock edge, which is the edge leaving the idle level. MISO is sampled on the trailing edge. Each edge takes one bit tick.
- R9: A start written while a transfer is in progress is ignored. The transfer in progress keeps its bit count.
- R10: Writing 1 to status bit 31 aborts any transfer. It releases chip select, returns the serial clock to idle and clears the done flag, the slave bit and all configuration registers. The buffer contents are kept, and bit 31 reads back 0.
- R11: Status bit 30 is a slave-mode select that reads back as written. While it is 1, a start is ignored.
- R12: The buffer can be read during a transfer and returns its contents at that moment, including bits already captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_tick_i | input | 1 | One-cycle enable from the clock divider; advances the serial clock by one edge |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte address (word-aligned) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on the address) |
| spi_sck_o | output | 1 | Serial clock |
| spi_mosi_o | output | 1 | Serial data out |
| spi_cs_o | output | 1 | Chip select, polarity set by configuration |
| spi_miso_i | input | 1 | Serial data in |

## Verification
The bench drives MISO from a slave model that presents each bit just after the leading edge. An engine that sampled on the leading edge would therefore capture stale data, and the buffer comparison would fail. Bit counts that are not whole bytes, single-byte and full 512-bit transfers expose off-by-one errors in the bits-minus-one count and a wrong bit order within a byte or word. A second start in mid-transfer, a soft reset in mid-transfer and a start in slave mode each check that stray commands neither restart nor extend a transfer. A held chip select chained into a released one must show exactly one release, so an engine that dropped chip select between chunks is caught.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

  // register offsets
  localparam int OFS_CMD  = 'h00;
  localparam int OFS_USER = 'h1C;
  localparam int OFS_BITS = 'h20;
  localparam int OFS_CSEL = 'h2C;
  localparam int OFS_STAT = 'h30;
  localparam int OFS_BUF  = 'h40;

  // field positions
  localparam int FB_START    = 18;
  localparam int FB_CAPTURE  = 0;
  localparam int FB_SCK_HI   = 7;
  localparam int FB_BITS_LSB = 17;
  localparam int FB_CS_HOLD  = 30;
  localparam int FB_CS_HI    = 23;
  localparam int FB_DONE     = 4;
  localparam int FB_SLAVE    = 30;
  localparam int FB_SRST     = 31;

  typedef struct packed {
    logic capture;
    logic sck_idle_hi;
    logic cs_hold;
    logic cs_act_hi;
    logic slave;
  } xfer_cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_TRAIL = 2'd2
  } shift_st_e;

endpackage

// File: rtl/spi_xfer_regs.sv
module spi_xfer_regs
  import spi_xfer_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int CNT_W  = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              busy_i,
  input  logic              xfer_end_i,
  output xfer_cfg_t         cfg_o,
  output logic [CNT_W-1:0]  bit_last_o,
  output logic              start_req_o,
  output logic              soft_rst_o,
  output logic [31:0]       rdata_o
);

  xfer_cfg_t        cfg_q;
  logic [CNT_W-1:0] bits_q;
  logic             done_q;

  logic hit_cmd, hit_user, hit_bits, hit_csel, hit_stat;
  assign hit_cmd  = addr_i == ADDR_W'(OFS_CMD);
  assign hit_user = addr_i == ADDR_W'(OFS_USER);
  assign hit_bits = addr_i == ADDR_W'(OFS_BITS);
  assign hit_csel = addr_i == ADDR_W'(OFS_CSEL);
  assign hit_stat = addr_i == ADDR_W'(OFS_STAT);

  assign start_req_o = we_i && hit_cmd && wdata_i[FB_START];
  assign soft_rst_o  = we_i && hit_stat && wdata_i[FB_SRST];

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      bits_q <= '0;
      done_q <= 1'b0;
    end else if (soft_rst_o) begin
      cfg_q  <= '0;
      bits_q <= '0;
      done_q <= 1'b0;
    end else begin
      if (we_i && hit_user) begin
        cfg_q.capture     <= wdata_i[FB_CAPTURE];
        cfg_q.sck_idle_hi <= wdata_i[FB_SCK_HI];
      end
      if (we_i && hit_bits) bits_q <= wdata_i[FB_BITS_LSB +: CNT_W];
      if (we_i && hit_csel) begin
        cfg_q.cs_hold   <= wdata_i[FB_CS_HOLD];
        cfg_q.cs_act_hi <= wdata_i[FB_CS_HI];
      end
      if (we_i && hit_stat) cfg_q.slave <= wdata_i[FB_SLAVE];
      if (xfer_end_i) done_q <= 1'b1;
      else if (we_i && hit_stat && !wdata_i[FB_DONE]) done_q <= 1'b0;
    end
  end

  assign cfg_o      = cfg_q;
  assign bit_last_o = bits_q;

  always_comb begin
    rdata_o = '0;
    if (hit_cmd) rdata_o[FB_START] = busy_i;
    if (hit_user) begin
      rdata_o[FB_CAPTURE] = cfg_q.capture;
      rdata_o[FB_SCK_HI]  = cfg_q.sck_idle_hi;
    end
    if (hit_bits) rdata_o[FB_BITS_LSB +: CNT_W] = bits_q;
    if (hit_csel) begin
      rdata_o[FB_CS_HOLD] = cfg_q.cs_hold;
      rdata_o[FB_CS_HI]   = cfg_q.cs_act_hi;
    end
    if (hit_stat) begin
      rdata_o[FB_SLAVE] = cfg_q.slave;
      rdata_o[FB_DONE]  = done_q;
    end
  end

  assert_done_on_end_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_end_i |=> done_q);

  assert_srst_clears_cfg_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> (cfg_q == '0) && !done_q && (bits_q == '0));

endmodule

// File: rtl/spi_xfer_buf.sv
module spi_xfer_buf #(
  parameter int WORDS  = 16,
  parameter int WIDX_W = $clog2(WORDS),
  parameter int BIT_W  = $clog2(WORDS * 32)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [WIDX_W-1:0] bus_widx_i,
  input  logic [31:0]       bus_wdata_i,
  input  logic [WIDX_W-1:0] bus_ridx_i,
  output logic [31:0]       bus_rdata_o,
  input  logic [BIT_W-1:0]  tx_idx_i,
  output logic              tx_bit_o,
  input  logic              cap_we_i,
  input  logic [BIT_W-1:0]  cap_idx_i,
  input  logic              cap_bit_i
);

  logic [WORDS-1:0][31:0] mem_q;

  // transfer bit n lives at flat position n^7: byte-major, MSB first in a byte
  logic [BIT_W-1:0] tx_pos, cap_pos;
  assign tx_pos  = tx_idx_i  ^ BIT_W'(7);
  assign cap_pos = cap_idx_i ^ BIT_W'(7);

  assign tx_bit_o    = mem_q[tx_pos[BIT_W-1:5]][tx_pos[4:0]];
  assign bus_rdata_o = mem_q[bus_ridx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
    end else begin
      for (int w = 0; w < WORDS; w++) begin
        if (bus_we_i && bus_widx_i == WIDX_W'(w)) mem_q[w] <= bus_wdata_i;
      end
      // capture wins over a bus write to the same bit
      if (cap_we_i) mem_q[cap_pos[BIT_W-1:5]][cap_pos[4:0]] <= cap_bit_i;
    end
  end

  assert_capture_lands_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_we_i |=> mem_q[$past(cap_pos[BIT_W-1:5])][$past(cap_pos[4:0])] == $past(cap_bit_i));

endmodule

// File: rtl/spi_xfer_shifter.sv
module spi_xfer_shifter
  import spi_xfer_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             tick_i,
  input  logic             start_req_i,
  input  xfer_cfg_t        cfg_i,
  input  logic [CNT_W-1:0] bit_last_i,
  input  logic             tx_bit_i,
  input  logic             miso_i,
  output logic             busy_o,
  output logic             xfer_end_o,
  output logic [CNT_W-1:0] bit_idx_o,
  output logic             cap_we_o,
  output logic             cap_bit_o,
  output logic             sck_act_o,
  output logic             mosi_o,
  output logic             cs_act_o
);

  shift_st_e        st_q;
  logic [CNT_W-1:0] idx_q, last_q;
  logic             sck_q, mosi_q, cs_q;
  logic             last_bit;

  assign last_bit = idx_q == last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      last_q <= '0;
      sck_q  <= 1'b0;
      mosi_q <= 1'b0;
      cs_q   <= 1'b0;
    end else if (soft_rst_i) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      last_q <= '0;
      sck_q  <= 1'b0;
      mosi_q <= 1'b0;
      cs_q   <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start_req_i && !cfg_i.slave) begin
            st_q   <= ST_LEAD;
            idx_q  <= '0;
            last_q <= bit_last_i;
            cs_q   <= 1'b1;
          end
        end
        ST_LEAD: begin
          if (tick_i) begin
            sck_q  <= 1'b1;
            mosi_q <= tx_bit_i;
            st_q   <= ST_TRAIL;
          end
        end
        ST_TRAIL: begin
          if (tick_i) begin
            sck_q <= 1'b0;
            if (last_bit) begin
              st_q <= ST_IDLE;
              cs_q <= cfg_i.cs_hold;
            end else begin
              idx_q <= idx_q + CNT_W'(1);
              st_q  <= ST_LEAD;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = st_q != ST_IDLE;
  assign xfer_end_o = (st_q == ST_TRAIL) && tick_i && last_bit && !soft_rst_i;
  assign cap_we_o   = (st_q == ST_TRAIL) && tick_i && cfg_i.capture && !soft_rst_i;
  assign cap_bit_o  = miso_i;
  assign bit_idx_o  = idx_q;
  assign sck_act_o  = sck_q;
  assign mosi_o     = mosi_q;
  assign cs_act_o   = cs_q;

  logic unused_cfg;
  assign unused_cfg = cfg_i.sck_idle_hi ^ cfg_i.cs_act_hi;

  assert_release_cs_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_end_o && !cfg_i.cs_hold |=> !cs_q);

  assert_hold_cs_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_end_o && cfg_i.cs_hold |=> cs_q);

  assert_sck_idle_when_free_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> !sck_q);

  assert_mosi_on_lead_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(st_q == ST_LEAD && tick_i) && !soft_rst_i |=> $stable(mosi_q));

  assert_idx_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |-> idx_q <= last_q);

  assert_busy_start_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) && start_req_i && !tick_i && !soft_rst_i |=> $stable(idx_q) && $stable(last_q));

  assert_slave_blocks_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) && cfg_i.slave |=> st_q == ST_IDLE);

  assert_srst_abort_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (st_q == ST_IDLE) && !cs_q && !sck_q);

endmodule

// File: rtl/spi_user_xfer.sv
module spi_user_xfer
  import spi_xfer_pkg::*;
#(
  parameter int BUF_WORDS = 16,
  parameter int ADDR_W    = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_tick_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              spi_sck_o,
  output logic              spi_mosi_o,
  output logic              spi_cs_o,
  input  logic              spi_miso_i
);

  localparam int BIT_W  = $clog2(BUF_WORDS * 32);
  localparam int WIDX_W = $clog2(BUF_WORDS);

  xfer_cfg_t        cfg;
  logic [BIT_W-1:0] bit_last, bit_idx;
  logic             start_req, soft_rst, busy, xfer_end;
  logic             tx_bit, cap_we, cap_bit;
  logic             sck_act, mosi, cs_act;
  logic [31:0]      ctl_rdata, buf_rdata;

  logic              buf_hit;
  logic [ADDR_W-1:0] buf_ofs;
  logic [WIDX_W-1:0] buf_idx;
  assign buf_hit = reg_addr_i >= ADDR_W'(OFS_BUF);
  assign buf_ofs = reg_addr_i - ADDR_W'(OFS_BUF);
  assign buf_idx = buf_ofs[WIDX_W+1:2];

  logic unused_ofs;
  assign unused_ofs = ^{buf_ofs[ADDR_W-1:WIDX_W+2], buf_ofs[1:0]};

  spi_xfer_regs #(.ADDR_W(ADDR_W), .CNT_W(BIT_W)) regs_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .busy_i      (busy),
    .xfer_end_i  (xfer_end),
    .cfg_o       (cfg),
    .bit_last_o  (bit_last),
    .start_req_o (start_req),
    .soft_rst_o  (soft_rst),
    .rdata_o     (ctl_rdata)
  );

  spi_xfer_buf #(.WORDS(BUF_WORDS)) buf_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_we_i    (reg_we_i && buf_hit),
    .bus_widx_i  (buf_idx),
    .bus_wdata_i (reg_wdata_i),
    .bus_ridx_i  (buf_idx),
    .bus_rdata_o (buf_rdata),
    .tx_idx_i    (bit_idx),
    .tx_bit_o    (tx_bit),
    .cap_we_i    (cap_we),
    .cap_idx_i   (bit_idx),
    .cap_bit_i   (cap_bit)
  );

  spi_xfer_shifter #(.CNT_W(BIT_W)) shift_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .soft_rst_i  (soft_rst),
    .tick_i      (bit_tick_i),
    .start_req_i (start_req),
    .cfg_i       (cfg),
    .bit_last_i  (bit_last),
    .tx_bit_i    (tx_bit),
    .miso_i      (spi_miso_i),
    .busy_o      (busy),
    .xfer_end_o  (xfer_end),
    .bit_idx_o   (bit_idx),
    .cap_we_o    (cap_we),
    .cap_bit_o   (cap_bit),
    .sck_act_o   (sck_act),
    .mosi_o      (mosi),
    .cs_act_o    (cs_act)
  );

  assign reg_rdata_o = buf_hit ? buf_rdata : ctl_rdata;
  assign spi_sck_o   = sck_act ^ cfg.sck_idle_hi;
  assign spi_cs_o    = cfg.cs_act_hi ? cs_act : !cs_act;
  assign spi_mosi_o  = mosi;

endmodule

// File: tb/spi_user_xfer_tb_top.sv
module spi_user_xfer_tb_top;

  localparam logic [6:0] A_CMD = 7'h00, A_USER = 7'h1C, A_BITS = 7'h20,
                         A_CSEL = 7'h2C, A_STAT = 7'h30, A_BUF = 7'h40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        we = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sck, mosi, cs;
  logic        miso = 1'b0;

  always #2.5 clk = ~clk;

  spi_user_xfer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bit_tick_i(tick),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .spi_sck_o(sck), .spi_mosi_o(mosi), .spi_cs_o(cs), .spi_miso_i(miso)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;
  int tick_div = 0;

  always @(negedge clk) tick <= ($urandom_range(0, tick_div) == 0);

  // slave model / monitor
  bit mon_en = 0, idle_m = 0, cs_hi_m = 0;
  bit mon_tx [512];
  bit sl_bits [512];
  int lead_cnt = 0, trail_cnt = 0, mosi_bad = 0, cs_rel = 0;
  logic prev_sck = 0, prev_mosi = 0, prev_cs = 1;

  always @(negedge clk) begin
    if (mon_en) begin
      if (sck !== prev_sck && prev_sck == idle_m) begin
        if (lead_cnt < 512) begin
          mon_tx[lead_cnt] = mosi;
          miso <= sl_bits[lead_cnt];
        end
        lead_cnt++;
      end else begin
        if (sck !== prev_sck) trail_cnt++;
        if (mosi !== prev_mosi) mosi_bad++;
      end
      if (prev_cs == cs_hi_m && cs != cs_hi_m) cs_rel++;
    end
    prev_sck = sck; prev_mosi = mosi; prev_cs = cs;
  end

  logic [31:0] orig [16];
  logic [31:0] shadow [16];

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog act=%0d exp=<190000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  function automatic bit orig_bit(input int n);
    int f = n ^ 7;
    return orig[f >> 5][f & 31];
  endfunction

  // mode: 0 plain, 1 second start mid-transfer, 2 buffer read mid-transfer
  task automatic run_xfer(input int nbits, input bit capt, input bit hold,
                          input bit idle_hi, input bit cs_hi, input int mode);
    logic [31:0] v;
    int mism, wmis, f;
    bit got, sent;
    logic [7:0] b0;
    mon_en = 0;
    idle_m = idle_hi; cs_hi_m = cs_hi;
    for (int w = 0; w < 16; w++) begin
      orig[w] = $urandom; shadow[w] = orig[w];
      wr(A_BUF + 7'(4 * w), orig[w]);
    end
    for (int n = 0; n < 512; n++) sl_bits[n] = 1'($urandom);
    wr(A_USER, (32'(idle_hi) << 7) | 32'(capt));
    wr(A_CSEL, (32'(hold) << 30) | (32'(cs_hi) << 23));
    wr(A_BITS, 32'(nbits - 1) << 17);
    wr(A_STAT, 32'h0);
    rd(A_STAT, v); chk("R4 done cleared", v, 32'h0);
    @(negedge clk);
    lead_cnt = 0; trail_cnt = 0; mosi_bad = 0; mon_en = 1;
    wr(A_CMD, 32'h1 << 18);
    if (nbits >= 8) begin rd(A_CMD, v); chk("R2 busy bit", v, 32'h1 << 18); end
    got = 0; sent = 0;
    for (int k = 0; k < 20000 && !got; k++) begin
      if (mode == 1 && !sent && lead_cnt >= nbits / 2) begin
        wr(A_CMD, 32'h1 << 18); sent = 1;
      end
      if (mode == 2 && !sent && trail_cnt >= 8) begin
        rd(A_BUF, v);
        for (int i = 0; i < 8; i++) b0[7 - i] = sl_bits[i];
        chk("R12 live buffer byte", {24'h0, v[7:0]}, {24'h0, b0});
        sent = 1;
      end
      rd(A_STAT, v); got = v[4];
    end
    chk("R4 done set", {31'h0, got}, 32'h1);
    repeat (3) @(negedge clk);
    chk(mode == 1 ? "R9 bit count after extra start" : "R3 bits shifted", lead_cnt, nbits);
    mism = 0;
    for (int n = 0; n < nbits; n++) if (mon_tx[n] != orig_bit(n)) mism++;
    chk("R2 mosi order", mism, 0);
    chk("R8 mosi only on leading edge", mosi_bad, 0);
    if (capt) for (int n = 0; n < nbits; n++) begin
      f = n ^ 7; shadow[f >> 5][f & 31] = sl_bits[n];
    end
    wmis = 0;
    for (int w = 0; w < 16; w++) begin
      rd(A_BUF + 7'(4 * w), v);
      if (v !== shadow[w]) wmis++;
    end
    chk("R5 buffer after transfer", wmis, 0);
    chk("R6 cs after end", {31'h0, cs}, {31'h0, hold ? cs_hi : !cs_hi});
    chk("R7 sck idle level", {31'h0, sck}, {31'h0, idle_hi});
    rd(A_STAT, v); chk("R4 status", v, 32'h10);
  endtask

  initial begin
    logic [31:0] v;
    int r0, l0, chg;
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(A_CMD, v);  chk("R1 cmd", v, 0);
    rd(A_USER, v); chk("R1 user", v, 0);
    rd(A_BITS, v); chk("R1 bits", v, 0);
    rd(A_CSEL, v); chk("R1 csel", v, 0);
    rd(A_STAT, v); chk("R1 status", v, 0);
    chk("R1 pins", {29'h0, cs, sck, mosi}, 32'h4);

    tick_div = 0; run_xfer(8,   1, 0, 0, 0, 0);   // R3 one byte
    tick_div = 2; run_xfer(512, 1, 0, 0, 0, 0);   // full buffer
    tick_div = 1; run_xfer(37,  0, 0, 0, 0, 0);   // R5 capture off
    tick_div = 1; run_xfer(21,  1, 0, 1, 1, 0);   // R7 inverted polarities

    // R6 chained transfers with held chip select
    wr(A_CSEL, 32'h0); repeat (2) @(negedge clk);
    r0 = cs_rel;
    tick_div = 1; run_xfer(16, 1, 1, 0, 0, 0);
    r0 = cs_rel - r0;
    chk("R6 no release while held", r0, 0);
    r0 = cs_rel;
    run_xfer(24, 1, 0, 0, 0, 0);
    chk("R6 one release after chain", cs_rel - r0, 1);

    tick_div = 2; run_xfer(64, 1, 0, 0, 0, 1);    // R9
    tick_div = 3; run_xfer(64, 1, 0, 0, 0, 2);    // R12

    // R10 soft reset mid-transfer
    mon_en = 0;
    wr(A_USER, 32'h80); wr(A_CSEL, (32'h1 << 30) | (32'h1 << 23));
    wr(A_BITS, 32'd255 << 17); wr(A_STAT, 0);
    idle_m = 1; cs_hi_m = 1; lead_cnt = 0;
    @(negedge clk); mon_en = 1;
    wr(A_CMD, 32'h1 << 18);
    while (lead_cnt < 20) @(negedge clk);
    mon_en = 0;
    wr(A_STAT, 32'h1 << 31);
    rd(A_STAT, v); chk("R10 status after reset", v, 0);
    rd(A_USER, v); chk("R10 user cleared", v, 0);
    rd(A_CSEL, v); chk("R10 csel cleared", v, 0);
    rd(A_CMD, v);  chk("R10 not busy", v, 0);
    chg = 0; prev_sck = sck;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk); if (sck !== 1'b0) chg++;
    end
    chk("R10 sck quiet", chg, 0);
    chk("R10 cs released", {31'h0, cs}, 32'h1);
    chg = 0;
    for (int w = 0; w < 16; w++) begin
      rd(A_BUF + 7'(4 * w), v); if (v !== shadow[w]) chg++;
    end
    chk("R10 buffer kept", chg, 0);

    // R11 slave mode blocks start
    wr(A_BITS, 32'd15 << 17);
    wr(A_STAT, 32'h1 << 30);
    rd(A_STAT, v); chk("R11 slave readback", v, 32'h1 << 30);
    idle_m = 0; cs_hi_m = 0; lead_cnt = 0;
    @(negedge clk); mon_en = 1;
    l0 = lead_cnt;
    wr(A_CMD, 32'h1 << 18);
    repeat (40) @(negedge clk);
    rd(A_CMD, v);  chk("R11 not busy", v, 0);
    chk("R11 no clocks", lead_cnt - l0, 0);
    rd(A_STAT, v); chk("R11 no done", v, 32'h1 << 30);
    wr(A_STAT, 0);

    // random mix
    for (int it = 0; it < 6; it++) begin
      tick_div = $urandom_range(0, 3);
      run_xfer($urandom_range(1, 512), 1'($urandom), 0, 1'($urandom), 1'($urandom), 0);
    end

    finished = 1;
    summary();
    $finish;
  end

endmodule